// File: doc/BRIEF.md
# Serial Command and Status Port

This block is the four-wire serial slave that sits in front of the operation sequencer of a voice message record and playback controller. A host lowers the select line and clocks in a 16-bit command word, least significant bit first. The same clocks carry a status word back to the host: the two interrupt flags followed by the sequencer's current row pointer. Readout and command therefore share a single full-duplex frame.

Nothing the host sends takes effect during the frame. Once the select line returns high, a frame that held exactly 16 clock pulses has its five control bits decoded into one operation request. That request goes to the sequencer with the 10-bit row address, a flag that says whether the address is loaded, and a cueing flag. The sequencer reports overflow and end-of-message events back. Either event latches a sticky flag that pulls the open-drain interrupt low. The flags clear at the start of the next frame. SCLK, select and MOSI come in asynchronously and are resynchronised to the system clock.

Top module: `spi_cmd_port`

## Requirements
- R1: A frame word is assembled LSB first from MOSI values taken at rising SCLK edges. Frame bit 0..9 are address A0..A9, bit 10 is ignored, and bits 11..15 are control bits C0..C4.
- R2: Only a frame with exactly 16 rising edges is decoded. With C4=1 and C2=1, C3=1 gives PLAY (op 4) and C3=0 gives REC (op 5). With C4=0 and C2=1, C1=1 gives STOP (op 2) and C1=0 gives POWERUP (op 1). With C4=0, C2=0 and C1=1, the result is STOP_POWERDOWN (op 3).
- R3: `cmd_addr` carries A0..A9. `cmd_addr_load` is 1 only for PLAY or REC with C1=0.
- R4: `cmd_cue` is 1 only for PLAY with C0=1. For every other operation, C0 has no effect.
- R5: A request is a single-cycle `cmd_valid` pulse. It is issued only after select rises, on the third clock edge after that rise.
- R6: A frame with any count of rising SCLK edges other than 16 issues no request.
- R7: MISO shows OVF first, then EOM, then row pointer P0..P9, then zeros. The values are snapshot at the start of the frame, and MISO changes only after falling SCLK edges.
- R8: `miso_oe` is 0 while select is high and 1 during a frame.
- R9: A `seq_ovf` or `seq_eom` pulse sets its flag and asserts `irq_pull` on the next clock. It stays asserted until a frame starts.
- R10: The start of any frame clears both flags and releases `irq_pull`. This holds even if the frame is later discarded.
- R11: Control codes that match none of the R2 patterns issue no request.
- R12: After reset, `cmd_valid`, `irq_pull` and `miso_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| ss_n | input | 1 | Active-low select from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial status data to host |
| miso_oe | output | 1 | MISO drive enable (0 = high impedance) |
| irq_pull | output | 1 | 1 = pull open-drain interrupt line low |
| row_ptr | input | ADDR_W | Current row pointer from sequencer |
| seq_ovf | input | 1 | Pulse: operation ended at end of memory |
| seq_eom | input | 1 | Pulse: operation ended at end-of-message marker |
| cmd_valid | output | 1 | One-cycle request strobe |
| cmd_op | output | 3 | Operation code (1..5, see R2) |
| cmd_addr | output | ADDR_W | Row address from the frame |
| cmd_addr_load | output | 1 | Load cmd_addr into the row counter |
| cmd_cue | output | 1 | Message cueing on a playback start |

## Verification
Each asynchronous input passes through two flops, and an edge acts on the third clock edge after the pin moves. A request therefore pulses three clocks after select rises, and a MISO bit changes three clocks after SCLK falls. The bench holds each SCLK level for at least five clocks. It reads MISO both just before each falling edge and six clocks after it, and it watches a ten-clock window after select rises for exactly one strobe. The interrupt responds one clock after a sequencer pulse. The bench samples it on the next falling clock edge, and again six clocks into the following frame, to see it released.

// File: rtl/spi_cmd_port.sv
module spi_cmd_port #(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic              irq_pull,
  input  logic [ADDR_W-1:0] row_ptr,
  input  logic              seq_ovf,
  input  logic              seq_eom,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_addr_load,
  output logic              cmd_cue
);
  localparam int CTRL_W  = 5;
  localparam int FRAME_W = ADDR_W + 1 + CTRL_W;
  localparam int STAT_W  = ADDR_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  localparam logic [2:0] OP_NONE   = 3'd0;
  localparam logic [2:0] OP_PWRUP  = 3'd1;
  localparam logic [2:0] OP_STOP   = 3'd2;
  localparam logic [2:0] OP_STOPPD = 3'd3;
  localparam logic [2:0] OP_PLAY   = 3'd4;
  localparam logic [2:0] OP_REC    = 3'd5;

  logic [SYNC_STAGES:0] sclk_q, ss_q, mosi_q;
  logic sclk_rise, sclk_fall, ss_fall, ss_rise, mosi_s;
  logic frame_on;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_W-1:0] in_sh;
  logic [STAT_W-1:0] out_sh;
  logic ovf_f, eom_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk};
      ss_q   <= {ss_q[SYNC_STAGES-1:0], ss_n};
      mosi_q <= {mosi_q[SYNC_STAGES-1:0], mosi};
    end

  assign sclk_rise =  sclk_q[SYNC_STAGES-1] & ~sclk_q[SYNC_STAGES];
  assign sclk_fall = ~sclk_q[SYNC_STAGES-1] &  sclk_q[SYNC_STAGES];
  assign ss_fall   = ~ss_q[SYNC_STAGES-1]   &  ss_q[SYNC_STAGES];
  assign ss_rise   =  ss_q[SYNC_STAGES-1]   & ~ss_q[SYNC_STAGES];
  assign mosi_s    =  mosi_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_on <= 1'b0;
      bit_cnt  <= '0;
      in_sh    <= '0;
      out_sh   <= '0;
    end else if (ss_fall) begin
      frame_on <= 1'b1;
      bit_cnt  <= '0;
      out_sh   <= {row_ptr, eom_f, ovf_f};
    end else if (ss_rise) begin
      frame_on <= 1'b0;
    end else if (frame_on) begin
      if (sclk_rise) begin
        in_sh <= {mosi_s, in_sh[FRAME_W-1:1]};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall) out_sh <= {1'b0, out_sh[STAT_W-1:1]};
    end

  assign miso    = out_sh[0];
  assign miso_oe = frame_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_f <= 1'b0;
      eom_f <= 1'b0;
    end else begin
      ovf_f <= (ovf_f & ~ss_fall) | seq_ovf;
      eom_f <= (eom_f & ~ss_fall) | seq_eom;
    end

  assign irq_pull = ovf_f | eom_f;

  logic [CTRL_W-1:0] ctl;
  logic [2:0] dec_op;
  assign ctl = in_sh[FRAME_W-1 -: CTRL_W];

  always_comb begin
    dec_op = OP_NONE;
    if (ctl[4]) begin
      if (ctl[2]) dec_op = ctl[3] ? OP_PLAY : OP_REC;
    end else if (ctl[2]) begin
      dec_op = ctl[1] ? OP_STOP : OP_PWRUP;
    end else if (ctl[1]) begin
      dec_op = OP_STOPPD;
    end
  end

  logic issue;
  assign issue = ss_rise & frame_on & (bit_cnt == CNT_FULL) & (dec_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_valid     <= 1'b0;
      cmd_op        <= OP_NONE;
      cmd_addr      <= '0;
      cmd_addr_load <= 1'b0;
      cmd_cue       <= 1'b0;
    end else begin
      cmd_valid <= issue;
      if (issue) begin
        cmd_op        <= dec_op;
        cmd_addr      <= in_sh[ADDR_W-1:0];
        cmd_addr_load <= dec_op[2] & ~ctl[1];
        cmd_cue       <= (dec_op == OP_PLAY) & ctl[0];
      end
    end

  // R5
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R5
  cmd_after_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ss_q[SYNC_STAGES]);
  // R11
  cmd_known_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != OP_NONE && cmd_op <= OP_REC));
  // R4
  cue_play_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_cue) |-> cmd_op == OP_PLAY);
  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_ovf || seq_eom) |=> irq_pull);
  // R10
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_fall && !seq_ovf && !seq_eom) |=> !irq_pull);
  // R8
  miso_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_rise |=> !miso_oe);
endmodule

// File: tb/tb_spi_cmd_port.sv
module tb_spi_cmd_port;
  localparam int AW = 10;
  logic clk = 0, rst_n = 0, sclk = 0, ss_n = 1, mosi = 0;
  logic [AW-1:0] row_ptr = '0;
  logic seq_ovf = 0, seq_eom = 0;
  logic miso, miso_oe, irq_pull, cmd_valid, cmd_addr_load, cmd_cue;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;

  spi_cmd_port #(.ADDR_W(AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .irq_pull(irq_pull), .row_ptr(row_ptr),
    .seq_ovf(seq_ovf), .seq_eom(seq_eom), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_addr_load(cmd_addr_load), .cmd_cue(cmd_cue));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] rx;
  int mid_bad, nvalid;
  bit oe_in_frame, irq_in_frame;
  logic [2:0] cap_op;
  logic [AW-1:0] cap_addr;
  logic cap_load, cap_cue;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int nbits);
    rx = '0; mid_bad = 0; nvalid = 0;
    ss_n = 0;
    tick(6);
    oe_in_frame = miso_oe;
    irq_in_frame = irq_pull;
    rx[0] = miso;
    for (int i = 0; i < nbits; i++) begin
      mosi = w[i % 16];
      tick(3);
      sclk = 1;
      tick(5);
      if (i < 16 && miso !== rx[i]) mid_bad++;
      sclk = 0;
      tick(6);
      if (i < 15) rx[i+1] = miso;
    end
    ss_n = 1;
    for (int k = 0; k < 10; k++) begin
      tick(1);
      if (cmd_valid) begin
        nvalid++;
        cap_op = cmd_op; cap_addr = cmd_addr;
        cap_load = cmd_addr_load; cap_cue = cmd_cue;
      end
    end
    tick(2);
  endtask

  function automatic int exp_op(input logic [4:0] c);
    if (c[4]) return c[2] ? (c[3] ? 4 : 5) : 0;
    if (c[2]) return c[1] ? 2 : 1;
    return c[1] ? 3 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(cmd_valid == 0, "R12 cmd_valid in reset", cmd_valid, 0);
    rst_n = 1;
    tick(4);
    chk(cmd_valid == 0, "R12 cmd_valid", cmd_valid, 0);
    chk(irq_pull == 0, "R12 irq_pull", irq_pull, 0);
    chk(miso_oe == 0, "R12 R8 miso_oe", miso_oe, 0);

    for (int code = 0; code < 32; code++) begin
      logic [4:0] c;
      logic [AW-1:0] a;
      int eo;
      c = code[4:0];
      a = AW'((code * 37 + 3) % 1024);
      row_ptr = a ^ 10'h2A5;
      frame({c, ~c[0], a}, 16);
      eo = exp_op(c);
      chk(rx == {4'b0, row_ptr, 2'b00}, "R7 status word", rx, {4'b0, row_ptr, 2'b00});
      chk(mid_bad == 0, "R7 miso stable over rising SCLK", mid_bad, 0);
      chk(oe_in_frame == 1, "R8 miso_oe in frame", oe_in_frame, 1);
      chk(miso_oe == 0, "R8 miso_oe idle", miso_oe, 0);
      if (eo == 0) begin
        chk(nvalid == 0, "R11 unlisted code silent", nvalid, 0);
      end else begin
        chk(nvalid == 1, "R5 one strobe", nvalid, 1);
        chk(cap_op == eo, "R2 decoded op", cap_op, eo);
        chk(cap_addr == a, "R1 R3 address bits", cap_addr, a);
        chk(cap_load == (eo >= 4 && !c[1]), "R3 address load", cap_load, (eo >= 4 && !c[1]));
        chk(cap_cue == (eo == 4 && c[0]), "R4 cue flag", cap_cue, (eo == 4 && c[0]));
      end
    end

    row_ptr = 10'h155;
    seq_ovf = 1; tick(1); seq_ovf = 0;
    chk(irq_pull == 1, "R9 irq after overflow", irq_pull, 1);
    tick(20);
    chk(irq_pull == 1, "R9 irq held", irq_pull, 1);
    frame({5'b00110, 1'b0, 10'h0AA}, 16);
    chk(irq_in_frame == 0, "R10 irq released at frame start", irq_in_frame, 0);
    chk(rx[1:0] == 2'b01, "R7 OVF then EOM bits", rx[1:0], 1);
    chk(rx[11:2] == row_ptr, "R7 row pointer", rx[11:2], row_ptr);
    chk(nvalid == 1 && cap_op == 2, "R2 STOP after readout", cap_op, 2);
    frame({5'b00100, 1'b0, 10'h000}, 16);
    chk(rx[1:0] == 2'b00, "R10 flags cleared", rx[1:0], 0);

    seq_eom = 1; tick(1); seq_eom = 0;
    chk(irq_pull == 1, "R9 irq after eom", irq_pull, 1);
    frame({5'b11110, 1'b0, 10'h123}, 8);
    chk(nvalid == 0, "R6 short frame dropped", nvalid, 0);
    chk(irq_in_frame == 0, "R10 irq released by short frame", irq_in_frame, 0);
    chk(rx[1:0] == 2'b10, "R7 EOM bit", rx[1:0], 2);
    frame({5'b11110, 1'b0, 10'h123}, 17);
    chk(nvalid == 0, "R6 long frame dropped", nvalid, 0);
    frame(16'h0, 0);
    chk(nvalid == 0, "R6 empty frame dropped", nvalid, 0);
    frame({5'b11110, 1'b1, 10'h3C1}, 16);
    chk(nvalid == 1 && cap_op == 4 && cap_addr == 10'h3C1, "R2 play after drops", cap_op, 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule